// File: doc/BRIEF.md
# Tuner Synthesiser Serial Control Front End

This block is the two-wire serial slave that sits in front of a phase-locked tuning synthesiser. It runs on a fast system clock and oversamples the bus clock and data lines. It recognises its own device address, which is made of a fixed upper part, a two-bit sub-address and a direction bit. It then loads the 15-bit programmable divide ratio, a control byte and a port-output byte into registers that drive the rest of the synthesiser.

In the read direction the block returns one status byte per acknowledged transfer. The status byte carries a power-on indication, the lock flag, three port input levels and the three-bit converter code. The data line is open-drain, so the block only asserts a drive-low output. A board-level detector presents the selectable sub-address as a two-bit code.

Top module: `tuner_i2c_regs`

## Requirements
- R1: The address byte, sent MSB first, is `1100 0 S1 S0 D`. D=0 starts a write transfer and D=1 starts a read transfer. Any other value in the upper five bits is not acknowledged, and the block leaves the bus alone until the next START.
- R2: Sub-address S1:S0 = 01 is accepted whatever `addr_sel_i` holds. Each other sub-address value is accepted only when `addr_sel_i` equals that value.
- R3: The block drives SDA low for the whole acknowledge clock that follows a matching address byte and every written data byte. It never drives SDA while it is idle, receiving an address or receiving data bits.
- R4: In a write, a data byte whose MSB is 0 carries divide-ratio bits 14..8 in its lower seven bits, and the following byte carries bits 7..0. A data byte whose MSB is 1 is the control byte, and it is output whole on `ctrl_o`. The byte after it is the port byte, and its bits 7..3 appear on `ports_o[4:0]`, where 1 means the output is switched on.
- R5: Several byte pairs may follow one address byte, and each completed pair takes effect without a new address.
- R6: A transfer that ends with a STOP partway through a byte leaves every output register at its previous value.
- R7: A read status byte is, from MSB to LSB: POR flag, `lock_i`, `port_lvl_i[2:0]`, `adc_i[2:0]`.
- R8: The block sends another status byte only after the master acknowledges the previous one. A missing acknowledge ends the read inside the block, so SDA stays released until the next START.
- R9: While `por_i` is high, and after `rst`, the divide ratio, the control byte and the port byte are all zero, which leaves every port output off.
- R10: The POR status flag is set by `rst` or `por_i`. It is cleared by a bus STOP that ends a read transfer, provided `por_i` is low at that time.
- R11: Byte 2 and byte 4 are held in shadow registers. `ratio_o`, `ctrl_o` and `ports_o` change only when the byte that completes a pair has been fully received. A pair that is left unfinished changes nothing, and the next transfer starts a fresh pair.
- R12: A repeated START restarts address decoding in the middle of a transfer. The new address then sets the direction and the pair sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_low_o | output | 1 | 1 pulls the open-drain data line low |
| addr_sel_i | input | 2 | Selectable sub-address code from the level detector |
| por_i | input | 1 | Supply-low indication |
| lock_i | input | 1 | Phase lock flag |
| port_lvl_i | input | 3 | Port input levels, returned in status bits 5..3 |
| adc_i | input | 3 | Converter code, returned in status bits 2..0 |
| ratio_o | output | 15 | Programmable divide ratio |
| ctrl_o | output | 8 | Control byte |
| ports_o | output | 5 | Port output enables from port byte bits 7..3 |

## Verification
The bench sweeps every pair of sub-address and selection code. This separates the always-accepted value from the pin-selected ones and shows that an upper address bit in error is rejected. Divide ratios spread over the whole 15-bit range are written to catch bit-placement faults between the high and low bytes. Frames that mix pairs, stop halfway through a pair or halfway through a byte, or restart with a repeated START show that the steering bit, the shadowing and the sequence reset behave as required. Status reads are swept over every input pattern, with acknowledge and with a missing acknowledge. The POR flag is followed across reset, a supply-low pulse and the STOP that ends a read.

// File: rtl/tuner_pkg.sv
package tuner_pkg;
    localparam int BYTE_W  = 8;
    localparam int RATIO_W = 15;
    localparam int PORT_W  = 5;
    localparam int SUB_W   = 2;
    localparam logic [4:0]       DEV_CODE   = 5'b11000;
    localparam logic [SUB_W-1:0] SUB_ALWAYS = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK, ST_WRITE, ST_READ, ST_RACK
    } bus_state_e;

    typedef enum logic [1:0] {
        EXP_FIRST, EXP_FREQ_LO, EXP_PORT
    } pair_exp_e;

    typedef struct packed {
        logic       por;
        logic       lock;
        logic [2:0] pin;
        logic [2:0] adc;
    } status_t;

    // upper seven bits of an address byte (direction bit excluded)
    function automatic logic addr_hit(input logic [6:0] a, input logic [SUB_W-1:0] sel);
        return (a[6:2] == DEV_CODE) && ((a[1:0] == SUB_ALWAYS) || (a[1:0] == sel));
    endfunction
endpackage

// File: rtl/tuner_bus_sync.sv
module tuner_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q, scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s    = scl_pipe[STAGES-1];
    assign sda_s    = sda_pipe[STAGES-1];
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tuner_bus_fsm.sv
module tuner_bus_fsm
    import tuner_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_s,
    input  logic             start_p,
    input  logic             stop_p,
    input  logic [SUB_W-1:0] addr_sel,
    input  logic [BW-1:0]    status,
    output logic             drive_low,
    output logic             byte_stb,
    output logic [BW-1:0]    byte_data,
    output logic             rd_stop,
    output bus_state_e       state
);
    localparam int CW = $clog2(BW);
    localparam logic [CW-1:0] LAST = CW'(BW - 1);

    logic [CW-1:0] cnt;
    logic [BW-1:0] sh;
    logic [1:0]    ph;
    logic          rw, rd_sess;

    assign byte_data = sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            sh        <= '0;
            ph        <= '0;
            rw        <= 1'b0;
            rd_sess   <= 1'b0;
            drive_low <= 1'b0;
            byte_stb  <= 1'b0;
            rd_stop   <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            rd_stop  <= 1'b0;
            if (start_p) begin
                state     <= ST_ADDR;
                cnt       <= '0;
                drive_low <= 1'b0;
            end else if (stop_p) begin
                state     <= ST_IDLE;
                drive_low <= 1'b0;
                rd_stop   <= rd_sess;
                rd_sess   <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: if (scl_rise) begin
                        sh  <= {sh[BW-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            if (addr_hit(sh[BW-2:0], addr_sel)) begin
                                state <= ST_ACK;
                                ph    <= '0;
                                rw    <= sda_s;
                                if (sda_s) rd_sess <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        if (ph == 2'd0) begin
                            ph        <= 2'd1;
                            drive_low <= 1'b1;
                        end else begin
                            cnt <= '0;
                            if (rw) begin
                                state     <= ST_READ;
                                sh        <= status;
                                drive_low <= ~status[BW-1];
                            end else begin
                                state     <= ST_WRITE;
                                drive_low <= 1'b0;
                            end
                        end
                    end
                    ST_WRITE: if (scl_rise) begin
                        sh  <= {sh[BW-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            byte_stb <= 1'b1;
                            state    <= ST_ACK;
                            ph       <= '0;
                        end
                    end
                    ST_READ: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST) begin
                                state <= ST_RACK;
                                ph    <= '0;
                            end
                        end else if (scl_fall) begin
                            sh        <= {sh[BW-2:0], 1'b0};
                            drive_low <= ~sh[BW-2];
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall && ph == 2'd0) begin
                            ph        <= 2'd1;
                            drive_low <= 1'b0;
                        end else if (scl_rise && ph == 2'd1) begin
                            if (sda_s) begin
                                state     <= ST_IDLE;
                                drive_low <= 1'b0;
                            end else begin
                                ph <= 2'd2;
                            end
                        end else if (scl_fall && ph == 2'd2) begin
                            state     <= ST_READ;
                            cnt       <= '0;
                            sh        <= status;
                            drive_low <= ~status[BW-1];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
    import tuner_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int RW = RATIO_W,
    parameter int PW = PORT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          por_i,
    input  logic          start_p,
    input  logic          byte_stb,
    input  logic [BW-1:0] byte_data,
    output logic [RW-1:0] ratio_o,
    output logic [BW-1:0] ctrl_o,
    output logic [PW-1:0] ports_o
);
    localparam int HI_W = RW - BW;

    pair_exp_e      expect_q;
    logic [HI_W-1:0] ratio_hi_sh;
    logic [BW-1:0]   ctrl_sh;

    always_ff @(posedge clk) begin
        if (rst || por_i) begin
            expect_q    <= EXP_FIRST;
            ratio_hi_sh <= '0;
            ctrl_sh     <= '0;
            ratio_o     <= '0;
            ctrl_o      <= '0;
            ports_o     <= '0;
        end else if (start_p) begin
            expect_q <= EXP_FIRST;
        end else if (byte_stb) begin
            unique case (expect_q)
                EXP_FIRST: begin
                    if (byte_data[BW-1]) begin
                        ctrl_sh  <= byte_data;
                        expect_q <= EXP_PORT;
                    end else begin
                        ratio_hi_sh <= byte_data[HI_W-1:0];
                        expect_q    <= EXP_FREQ_LO;
                    end
                end
                EXP_FREQ_LO: begin
                    ratio_o  <= {ratio_hi_sh, byte_data};
                    expect_q <= EXP_FIRST;
                end
                EXP_PORT: begin
                    ctrl_o   <= ctrl_sh;
                    ports_o  <= byte_data[BW-1 -: PW];
                    expect_q <= EXP_FIRST;
                end
                default: expect_q <= EXP_FIRST;
            endcase
        end
    end
endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
    import tuner_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_drive_low_o,
    input  logic [SUB_W-1:0]   addr_sel_i,
    input  logic               por_i,
    input  logic               lock_i,
    input  logic [2:0]         port_lvl_i,
    input  logic [2:0]         adc_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic [BYTE_W-1:0]  ctrl_o,
    output logic [PORT_W-1:0]  ports_o
);
    logic sda_s, scl_rise, scl_fall, start_w, stop_w;
    logic byte_stb_w, rd_stop_w, por_flag;
    logic [BYTE_W-1:0] byte_w;
    bus_state_e state_w;
    status_t    stat;

    always_ff @(posedge clk) begin
        if (rst || por_i) por_flag <= 1'b1;
        else if (rd_stop_w) por_flag <= 1'b0;
    end

    always_comb begin
        stat.por  = por_flag;
        stat.lock = lock_i;
        stat.pin  = port_lvl_i;
        stat.adc  = adc_i;
    end

    tuner_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_w), .stop_p(stop_w)
    );

    tuner_bus_fsm #(.BW(BYTE_W)) u_fsm (
        .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_p(start_w), .stop_p(stop_w),
        .addr_sel(addr_sel_i), .status(stat),
        .drive_low(sda_drive_low_o), .byte_stb(byte_stb_w),
        .byte_data(byte_w), .rd_stop(rd_stop_w), .state(state_w)
    );

    tuner_reg_bank #(.BW(BYTE_W), .RW(RATIO_W), .PW(PORT_W)) u_regs (
        .clk(clk), .rst(rst), .por_i(por_i), .start_p(start_w),
        .byte_stb(byte_stb_w), .byte_data(byte_w),
        .ratio_o(ratio_o), .ctrl_o(ctrl_o), .ports_o(ports_o)
    );
endmodule

// File: rtl/tuner_i2c_regs_chk.sv
module tuner_i2c_regs_chk
    import tuner_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               por_i,
    input logic               start_p,
    input logic               stop_p,
    input logic               byte_stb,
    input bus_state_e         state,
    input logic               drive_low,
    input logic [RATIO_W-1:0] ratio_o,
    input logic [BYTE_W-1:0]  ctrl_o,
    input logic [PORT_W-1:0]  ports_o
);
    p_quiet_bus_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_ADDR || state == ST_WRITE) |-> !drive_low);

    p_byte_from_write_r4: assert property (@(posedge clk) disable iff (rst)
        byte_stb |-> $past(state) == ST_WRITE);

    p_ratio_atomic_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(byte_stb) && !$past(por_i)) |-> $stable(ratio_o));

    p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(byte_stb) && !$past(por_i)) |-> ($stable(ctrl_o) && $stable(ports_o)));

    p_por_clear_r9: assert property (@(posedge clk) disable iff (rst)
        por_i |=> (ratio_o == '0 && ctrl_o == '0 && ports_o == '0));

    p_stop_release_r8: assert property (@(posedge clk) disable iff (rst)
        stop_p |=> (state == ST_IDLE && !drive_low));

    p_restart_addr_r12: assert property (@(posedge clk) disable iff (rst)
        start_p |=> state == ST_ADDR);
endmodule

bind tuner_i2c_regs tuner_i2c_regs_chk u_chk (
    .clk(clk), .rst(rst), .por_i(por_i), .start_p(start_w), .stop_p(stop_w),
    .byte_stb(byte_stb_w), .state(state_w), .drive_low(sda_drive_low_o),
    .ratio_o(ratio_o), .ctrl_o(ctrl_o), .ports_o(ports_o)
);

// File: tb/tuner_i2c_regs_bench.sv
module tuner_i2c_regs_bench;
    localparam int Q = 10;
    localparam int H = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic scl = 1'b1, sda_m = 1'b1;
    logic [1:0] sel = 2'd0;
    logic por = 1'b0, lock = 1'b0;
    logic [2:0] pin = '0, adc = '0;
    wire  drv;
    wire  sda_line = sda_m & ~drv;
    wire  [14:0] ratio;
    wire  [7:0]  ctrl;
    wire  [4:0]  ports;

    int errors = 0, checks = 0;
    logic done = 1'b0;
    logic pf = 1'b1;

    tuner_i2c_regs u_tuner_i2c_regs (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .sda_drive_low_o(drv), .addr_sel_i(sel), .por_i(por),
        .lock_i(lock), .port_lvl_i(pin), .adc_i(adc),
        .ratio_o(ratio), .ctrl_o(ctrl), .ports_o(ports)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(H); sda_m = 1'b1; tick(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q); scl = 1'b1; tick(H); scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic v);
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(H/2); v = sda_line; tick(H/2); scl = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(a);
        ack = ~a;
    endtask

    task automatic get_byte(input logic ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        put_bit(~ack);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] exp_status();
        return {pf, lock, pin, adc};
    endfunction

    // write frame carrying one frequency pair, device sub-address 01
    task automatic write_ratio(input logic [14:0] v);
        logic a0, a1, a2;
        bus_start();
        put_byte(8'hC2, a0);
        put_byte({1'b0, v[14:8]}, a1);
        put_byte(v[7:0], a2);
        bus_stop();
        chk(a0 && a1 && a2, "R3 ack on address and data", {a0, a1, a2}, 3'b111);
        chk(ratio == v, "R4 divide ratio placement", ratio, v);
    endtask

    initial begin
        logic a, b, c;
        logic [7:0] d;
        logic [14:0] v, held;
        tick(5);
        rst = 1'b0;
        tick(5);
        chk(ratio == 0 && ctrl == 0 && ports == 0, "R9 state after reset", {ratio, ctrl, ports}, 0);
        chk(drv == 1'b0, "R3 released after reset", drv, 0);

        // R1/R2 sweep of sub-address against selection code
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 4; m++) begin
                sel = 2'(s);
                bus_start();
                put_byte({5'b11000, 2'(m), 1'b0}, a);
                bus_stop();
                chk(a == (m == 1 || m == s), "R2 sub-address acceptance", a, (m == 1 || m == s));
            end
        end
        sel = 2'd0;
        bus_start();
        put_byte(8'hE2, a);
        bus_stop();
        chk(a == 1'b0, "R1 wrong fixed address bits", a, 0);

        // R4 ratio sweep across the range
        for (int k = 0; k < 8; k++) begin
            v = 15'((k * 13107 + 77) & 16'h7FFF);
            write_ratio(v);
        end
        write_ratio(15'h7FFF);
        write_ratio(15'h0000);

        // R4 control and port pair
        bus_start();
        put_byte(8'hC2, a); put_byte(8'h8E, b); put_byte(8'hA8, c);
        bus_stop();
        chk(ctrl == 8'h8E, "R4 control byte", ctrl, 8'h8E);
        chk(ports == 5'b10101, "R4 port byte bits 7..3", ports, 5'b10101);

        // R5 several pairs in one frame
        bus_start();
        put_byte(8'hC2, a);
        put_byte(8'h12, b); put_byte(8'h34, c);
        chk(ratio == 15'h1234, "R5 first pair in frame", ratio, 15'h1234);
        put_byte(8'hF1, b); put_byte(8'h58, c);
        chk(ctrl == 8'hF1 && ports == 5'b01011, "R5 control pair in frame", {ctrl, ports}, {8'hF1, 5'b01011});
        put_byte(8'h6A, b); put_byte(8'hCD, c);
        bus_stop();
        chk(ratio == 15'h6ACD, "R5 third pair in frame", ratio, 15'h6ACD);

        // R11 half pair holds, next frame restarts the pair
        held = ratio;
        bus_start();
        put_byte(8'hC2, a); put_byte(8'h01, b);
        chk(ratio == held, "R11 ratio after byte 2 only", ratio, held);
        bus_stop();
        bus_start();
        put_byte(8'hC2, a); put_byte(8'h83, b); put_byte(8'h08, c);
        bus_stop();
        chk(ratio == held, "R11 unfinished pair discarded", ratio, held);
        chk(ctrl == 8'h83 && ports == 5'b00001, "R11 fresh pair after new frame", {ctrl, ports}, {8'h83, 5'b00001});

        // R6 stop partway through a byte
        bus_start();
        put_byte(8'hC2, a);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        chk(ctrl == 8'h83 && ports == 5'b00001, "R6 stop in byte keeps control", {ctrl, ports}, {8'h83, 5'b00001});
        bus_start();
        put_byte(8'hC2, a); put_byte(8'h22, b);
        for (int i = 0; i < 5; i++) put_bit(1'b0);
        bus_stop();
        chk(ratio == held, "R6 stop in byte 3 keeps ratio", ratio, held);

        // R12 repeated start restarts decoding and pairing
        bus_start();
        put_byte(8'hC2, a); put_byte(8'h3F, b);
        bus_start();
        put_byte(8'hC2, a); put_byte(8'hC4, b); put_byte(8'h40, c);
        bus_stop();
        chk(ratio == held, "R12 ratio after restart", ratio, held);
        chk(ctrl == 8'hC4 && ports == 5'b01000, "R12 pair after restart", {ctrl, ports}, {8'hC4, 5'b01000});

        // R7/R10 first read shows POR flag, the STOP clears it
        lock = 1'b1; pin = 3'b101; adc = 3'b011;
        bus_start();
        put_byte(8'hC3, a);
        chk(a == 1'b1, "R1 read address acknowledged", a, 1);
        get_byte(1'b0, d);
        bus_stop();
        chk(d == 8'hEB, "R7 R10 status with POR flag", d, 8'hEB);
        pf = 1'b0;
        bus_start(); put_byte(8'hC3, a); get_byte(1'b0, d); bus_stop();
        chk(d == exp_status(), "R10 POR flag cleared by stop", d, exp_status());

        // R7/R8 status sweep with acknowledge then missing acknowledge
        for (int k = 0; k < 8; k++) begin
            lock = k[0]; pin = 3'(k); adc = 3'(7 - k);
            bus_start();
            put_byte(8'hC3, a);
            get_byte(1'b1, d);
            chk(d == exp_status(), "R7 status byte fields", d, exp_status());
            get_byte(1'b0, d);
            chk(d == exp_status(), "R8 byte after acknowledge", d, exp_status());
            get_byte(1'b0, d);
            chk(d == 8'hFF, "R8 no data after missing acknowledge", d, 8'hFF);
            bus_stop();
        end

        // R9 supply-low pulse clears registers, R10 flag set again
        por = 1'b1; tick(4);
        chk(ratio == 0 && ctrl == 0 && ports == 0, "R9 cleared while por high", {ratio, ctrl, ports}, 0);
        por = 1'b0; pf = 1'b1; tick(4);
        chk(ratio == 0 && ctrl == 0 && ports == 0, "R9 stays clear after por", {ratio, ctrl, ports}, 0);
        // R12 restart from write into read
        bus_start(); put_byte(8'hC2, a); put_byte(8'h11, b);
        bus_start(); put_byte(8'hC3, a); get_byte(1'b0, d); bus_stop();
        chk(d == exp_status(), "R10 R12 POR flag in read after restart", d, exp_status());
        chk(ratio == 0, "R12 half pair dropped by restart", ratio, 0);
        pf = 1'b0;
        bus_start(); put_byte(8'hC3, a); get_byte(1'b0, d); bus_stop();
        chk(d == exp_status(), "R10 flag cleared again", d, exp_status());

        // R2 read to a non-selected sub-address leaves the line alone
        sel = 2'd3;
        bus_start(); put_byte(8'hC5, a);
        chk(a == 1'b0, "R2 unselected read address", a, 0);
        get_byte(1'b0, d);
        bus_stop();
        chk(d == 8'hFF, "R1 ignored transfer leaves line high", d, 8'hFF);
        write_ratio(15'h2A55);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule